// File: doc/BRIEF.md
# Instruction Field Decoder

This block takes one 32-bit instruction word and, in the same cycle, splits it into its fields, extends its immediate, picks the execution-unit class and decides whether the instruction may write a register. There are three word layouts. The J layout is used by the two absolute-jump opcodes. The R layout is entered only through the primary opcode 0x3A, whose extended opcode is then looked up in a second table. Every other primary opcode uses the I layout.

The decoder also raises three exception flags. Illegal covers unassigned opcodes. Unimplemented covers the custom-instruction opcode. Supervisor covers privileged instructions issued in user mode. It never produces a write to register 0.

The word arrives on a valid/ready stream and the decoded result leaves on a second valid/ready stream. There is no storage between them. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, so back-pressure from the consumer stalls the producer in the same cycle. The producer holds the word stable while `in_valid` is high and `in_ready` is low.

Top module: `rid_decoder`

## Requirements
- R1: Fields are taken from fixed bit positions:
  - `opcode_o` from [5:0]
  - `ra_o` from [31:27]
  - `rb_o` from [26:22]
  - `rc_o` from [21:17]
  - `opx_o` from [16:11]

  The outputs carry these raw bits whatever the layout.
- R2: `fmt_o` encodes the layout: 1 (R) when the opcode is 0x3A, 2 (J) for opcodes 0x00 and 0x01, and 0 (I) otherwise. The extended opcode affects decoding only under 0x3A.
- R3: For I-layout words, the 16-bit immediate in [21:6] is sign-extended to 32 bits for addi (0x04), muli (0x24), signed compares (0x08, 0x10, 0x18, 0x20), loads, stores, branches and every other I-layout opcode not named in R4 or R5.
- R4: The immediate is zero-extended for andi (0x0C), ori (0x14), xori (0x1C), cmpgeui (0x28) and cmpltui (0x30).
- R5: For the high logical forms andhi (0x2C), orhi (0x34) and xorhi (0x3C), the immediate is placed in [31:16] with zeros in [15:0].
- R6: An R-layout word yields its 5-bit field [10:6], zero-extended. A J-layout word yields its 26-bit field [31:6], zero-extended.
- R7: An unassigned primary or extended opcode sets `exc_o[0]` (illegal). Examples are primary 0x02 and extended 0x00.
- R8: Primary opcode 0x32 (custom) sets `exc_o[1]` (unimplemented).
- R9: The privileged extended opcodes are control read 0x26, control write 0x2E, exception return 0x01 and debug return 0x09. With `user_mode_i` high they set `exc_o[2]` (supervisor). With it low they decode as class CTRL.
- R10: The shadow-register opcodes are primary 0x38 (read) and extended 0x14 (write). With parameter `SHADOW_EN`=0 they are illegal. With `SHADOW_EN`=1 they are class CTRL and privileged as in R9.
- R11: Register write targets depend on the instruction:
  - I-layout result ops write B.
  - R-layout result ops write C.
  - call (0x00) and callr (extended 0x1D) write register 31.
  - Stores, branches, jumps, returns, control writes, trap (0x2D) and break (0x34) do not write.

  `wb_en_o` is never high with `wb_reg_o` equal to 0.
- R12: At most one `exc_o` bit is set, with priority illegal over unimplemented over supervisor. When any bit is set, `exc_valid_o` is high, `cls_o` is EXC and `wb_en_o` is low.
- R13: The cache-maintenance opcodes and the no-op decode as class NOP, with no write and no exception:
  - primary 0x13, 0x1B, 0x33 and 0x3B
  - extended 0x04, 0x0C and 0x29
  - the no-op, extended 0x36
- R14: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, with no cycle of delay.

`cls_o` takes the values of `rid_pkg::cls_e`: NOP, ALU, MUL, DIV, SHIFT, CMP, LOAD, STORE, BRANCH, JUMP, CTRL, TRAP, EXC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can accept the word (follows out_ready) |
| instr_i | input | 32 | Instruction word |
| user_mode_i | input | 1 | Processor is in user mode |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer accepts the result |
| fmt_o | output | 2 | Layout: 0 I, 1 R, 2 J |
| opcode_o | output | 6 | Primary opcode |
| opx_o | output | 6 | Extended opcode field |
| ra_o | output | 5 | Register A index |
| rb_o | output | 5 | Register B index |
| rc_o | output | 5 | Register C index |
| imm_o | output | 32 | Extended immediate |
| cls_o | output | 4 | Execution-unit class |
| wb_en_o | output | 1 | Register write enabled |
| wb_reg_o | output | 5 | Register to be written |
| exc_o | output | 3 | One-hot exception: [0] illegal, [1] unimplemented, [2] supervisor |
| exc_valid_o | output | 1 | Any exception flag set |

## Verification
The bench builds two copies of the decoder. The first uses `SHADOW_EN`=0 and runs the whole vector table. The second uses `SHADOW_EN`=1 and is driven with the same words. Only the second copy makes the shadow-register read and write reachable as legal, privileged CTRL instructions. That lets both sides of R10, and the supervisor check on those opcodes, be observed at the ports. The other parameters stay at their defaults: a 6-bit opcode, 5-bit register indices and register 31 as the link register.

// File: rtl/rid_pkg.sv
package rid_pkg;

  typedef enum logic [3:0] {
    CL_NOP    = 4'd0,
    CL_ALU    = 4'd1,
    CL_MUL    = 4'd2,
    CL_DIV    = 4'd3,
    CL_SHIFT  = 4'd4,
    CL_CMP    = 4'd5,
    CL_LOAD   = 4'd6,
    CL_STORE  = 4'd7,
    CL_BRANCH = 4'd8,
    CL_JUMP   = 4'd9,
    CL_CTRL   = 4'd10,
    CL_TRAP   = 4'd11,
    CL_EXC    = 4'd12
  } cls_e;

  typedef enum logic [1:0] {
    FMT_I = 2'd0,
    FMT_R = 2'd1,
    FMT_J = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    IM_SEXT = 2'd0,
    IM_ZEXT = 2'd1,
    IM_HIGH = 2'd2
  } imm_mode_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_B    = 2'd1,
    WB_C    = 2'd2,
    WB_LINK = 2'd3
  } wb_sel_e;

  localparam int EXC_W      = 3;
  localparam int EXC_ILL    = 0;
  localparam int EXC_UNIMPL = 1;
  localparam int EXC_PRIV   = 2;

  typedef struct packed {
    cls_e      cls;
    fmt_e      fmt;
    imm_mode_e imode;
    wb_sel_e   wsel;
    logic      illegal;
    logic      unimpl;
    logic      priv;
  } dec_t;

  localparam dec_t DEC_ILLEGAL = '{cls: CL_NOP, fmt: FMT_I, imode: IM_SEXT,
                                   wsel: WB_NONE, illegal: 1'b1,
                                   unimpl: 1'b0, priv: 1'b0};

endpackage

// File: rtl/rid_fields.sv
module rid_fields #(
  parameter int WORD_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5
) (
  input  logic [WORD_W-1:0]        word_i,
  output logic [OP_W-1:0]          op_o,
  output logic [OP_W-1:0]          opx_o,
  output logic [REG_W-1:0]         ra_o,
  output logic [REG_W-1:0]         rb_o,
  output logic [REG_W-1:0]         rc_o,
  output logic [REG_W-1:0]         imm5_o,
  output logic [WORD_W-OP_W-1:0]   imm26_o,
  output logic [WORD_W-OP_W-2*REG_W-1:0] imm16_o
);
  localparam int RA_LSB  = WORD_W - REG_W;
  localparam int RB_LSB  = RA_LSB - REG_W;
  localparam int RC_LSB  = RB_LSB - REG_W;
  localparam int OPX_LSB = OP_W + REG_W;
  localparam int I16_W   = WORD_W - OP_W - 2*REG_W;

  assign op_o    = word_i[OP_W-1:0];
  assign imm5_o  = word_i[OP_W +: REG_W];
  assign opx_o   = word_i[OPX_LSB +: OP_W];
  assign rc_o    = word_i[RC_LSB +: REG_W];
  assign rb_o    = word_i[RB_LSB +: REG_W];
  assign ra_o    = word_i[RA_LSB +: REG_W];
  assign imm16_o = word_i[OP_W +: I16_W];
  assign imm26_o = word_i[WORD_W-1:OP_W];
endmodule

// File: rtl/rid_primary_tbl.sv
module rid_primary_tbl
  import rid_pkg::*;
#(
  parameter int OP_W      = 6,
  parameter bit SHADOW_EN = 1'b0
) (
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  function automatic dec_t mk(cls_e c, imm_mode_e m, wb_sel_e w);
    dec_t d;
    d = '{cls: c, fmt: FMT_I, imode: m, wsel: w,
          illegal: 1'b0, unimpl: 1'b0, priv: 1'b0};
    return d;
  endfunction

  always_comb begin
    dec_o = DEC_ILLEGAL;
    case (op_i)
      6'h00: begin dec_o = mk(CL_JUMP, IM_SEXT, WB_LINK); dec_o.fmt = FMT_J; end
      6'h01: begin dec_o = mk(CL_JUMP, IM_SEXT, WB_NONE); dec_o.fmt = FMT_J; end
      6'h03, 6'h07, 6'h0B, 6'h0F, 6'h17,
      6'h23, 6'h27, 6'h2B, 6'h2F, 6'h37: dec_o = mk(CL_LOAD, IM_SEXT, WB_B);
      6'h05, 6'h0D, 6'h15, 6'h25, 6'h2D, 6'h35: dec_o = mk(CL_STORE, IM_SEXT, WB_NONE);
      6'h06, 6'h0E, 6'h16, 6'h1E,
      6'h26, 6'h2E, 6'h36: dec_o = mk(CL_BRANCH, IM_SEXT, WB_NONE);
      6'h04: dec_o = mk(CL_ALU, IM_SEXT, WB_B);
      6'h24: dec_o = mk(CL_MUL, IM_SEXT, WB_B);
      6'h0C, 6'h14, 6'h1C: dec_o = mk(CL_ALU, IM_ZEXT, WB_B);
      6'h2C, 6'h34, 6'h3C: dec_o = mk(CL_ALU, IM_HIGH, WB_B);
      6'h08, 6'h10, 6'h18, 6'h20: dec_o = mk(CL_CMP, IM_SEXT, WB_B);
      6'h28, 6'h30: dec_o = mk(CL_CMP, IM_ZEXT, WB_B);
      6'h13, 6'h1B, 6'h33, 6'h3B: dec_o = mk(CL_NOP, IM_SEXT, WB_NONE);
      6'h32: begin dec_o = mk(CL_NOP, IM_SEXT, WB_NONE); dec_o.unimpl = 1'b1; end
      6'h38: begin
        if (SHADOW_EN) begin
          dec_o = mk(CL_CTRL, IM_SEXT, WB_B);
          dec_o.priv = 1'b1;
        end
      end
      default: dec_o = DEC_ILLEGAL;
    endcase
  end

  always_comb begin
    if (!$isunknown(op_i)) begin
      assert_j_only_low_R2: assert (dec_o.fmt != FMT_J || op_i < 6'h02)
        else $error("J layout decoded for opcode %h", op_i);
    end
  end
endmodule

// File: rtl/rid_ext_tbl.sv
module rid_ext_tbl
  import rid_pkg::*;
#(
  parameter int OP_W      = 6,
  parameter bit SHADOW_EN = 1'b0
) (
  input  logic [OP_W-1:0] opx_i,
  output dec_t            dec_o
);
  function automatic dec_t mk(cls_e c, wb_sel_e w, logic p);
    dec_t d;
    d = '{cls: c, fmt: FMT_R, imode: IM_ZEXT, wsel: w,
          illegal: 1'b0, unimpl: 1'b0, priv: p};
    return d;
  endfunction

  always_comb begin
    dec_o = DEC_ILLEGAL;
    dec_o.fmt = FMT_R;
    case (opx_i)
      6'h01, 6'h09: dec_o = mk(CL_CTRL, WB_NONE, 1'b1);
      6'h26:        dec_o = mk(CL_CTRL, WB_C, 1'b1);
      6'h2E:        dec_o = mk(CL_CTRL, WB_NONE, 1'b1);
      6'h05, 6'h0D: dec_o = mk(CL_JUMP, WB_NONE, 1'b0);
      6'h1D:        dec_o = mk(CL_JUMP, WB_LINK, 1'b0);
      6'h02, 6'h03, 6'h0B, 6'h12, 6'h13,
      6'h1A, 6'h1B, 6'h3A, 6'h3B: dec_o = mk(CL_SHIFT, WB_C, 1'b0);
      6'h06, 6'h0E, 6'h16, 6'h1E,
      6'h31, 6'h39, 6'h1C: dec_o = mk(CL_ALU, WB_C, 1'b0);
      6'h07, 6'h17, 6'h1F, 6'h27: dec_o = mk(CL_MUL, WB_C, 1'b0);
      6'h24, 6'h25: dec_o = mk(CL_DIV, WB_C, 1'b0);
      6'h08, 6'h10, 6'h18, 6'h20,
      6'h28, 6'h30: dec_o = mk(CL_CMP, WB_C, 1'b0);
      6'h04, 6'h0C, 6'h29, 6'h36: dec_o = mk(CL_NOP, WB_NONE, 1'b0);
      6'h2D, 6'h34: dec_o = mk(CL_TRAP, WB_NONE, 1'b0);
      6'h14: begin
        if (SHADOW_EN) dec_o = mk(CL_CTRL, WB_NONE, 1'b1);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown(opx_i)) begin
      assert_nop_quiet_R13: assert (dec_o.cls != CL_NOP || dec_o.illegal ||
                                    (dec_o.wsel == WB_NONE && !dec_o.priv))
        else $error("no-op class with side effect at opx %h", opx_i);
    end
  end
endmodule

// File: rtl/rid_imm_unit.sv
module rid_imm_unit
  import rid_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5
) (
  input  fmt_e                              fmt_i,
  input  imm_mode_e                         mode_i,
  input  logic [WORD_W-OP_W-2*REG_W-1:0]    imm16_i,
  input  logic [REG_W-1:0]                  imm5_i,
  input  logic [WORD_W-OP_W-1:0]            imm26_i,
  output logic [WORD_W-1:0]                 imm_o
);
  localparam int I16_W = WORD_W - OP_W - 2*REG_W;
  localparam int I26_W = WORD_W - OP_W;

  logic [WORD_W-1:0] i_ext;

  always_comb begin
    case (mode_i)
      IM_ZEXT: i_ext = {{(WORD_W-I16_W){1'b0}}, imm16_i};
      IM_HIGH: i_ext = {imm16_i, {(WORD_W-I16_W){1'b0}}};
      default: i_ext = {{(WORD_W-I16_W){imm16_i[I16_W-1]}}, imm16_i};
    endcase
  end

  always_comb begin
    case (fmt_i)
      FMT_R:   imm_o = {{(WORD_W-REG_W){1'b0}}, imm5_i};
      FMT_J:   imm_o = {{(WORD_W-I26_W){1'b0}}, imm26_i};
      default: imm_o = i_ext;
    endcase
  end

  always_comb begin
    if (!$isunknown({fmt_i, mode_i, imm16_i})) begin
      assert_high_clear_R5: assert (!(fmt_i == FMT_I && mode_i == IM_HIGH) ||
                                    imm_o[I16_W-1:0] == '0)
        else $error("high immediate has low bits set");
    end
  end
endmodule

// File: rtl/rid_decoder.sv
module rid_decoder
  import rid_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int OP_W      = 6,
  parameter int REG_W     = 5,
  parameter bit SHADOW_EN = 1'b0,
  parameter int LINK_REG  = 31,
  parameter int R_OPCODE  = 'h3A
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              user_mode_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        fmt_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic [OP_W-1:0]   opx_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [REG_W-1:0]  rc_o,
  output logic [WORD_W-1:0] imm_o,
  output logic [3:0]        cls_o,
  output logic              wb_en_o,
  output logic [REG_W-1:0]  wb_reg_o,
  output logic [EXC_W-1:0]  exc_o,
  output logic              exc_valid_o
);
  localparam int I16_W = WORD_W - OP_W - 2*REG_W;
  localparam int I26_W = WORD_W - OP_W;
  localparam logic [OP_W-1:0]  R_OP  = OP_W'(R_OPCODE);
  localparam logic [REG_W-1:0] LINK  = REG_W'(LINK_REG);

  logic [OP_W-1:0]  op, opx;
  logic [REG_W-1:0] ra, rb, rc, imm5;
  logic [I16_W-1:0] imm16;
  logic [I26_W-1:0] imm26;
  dec_t             prim_dec, ext_dec, dec;
  logic             is_r;
  logic [EXC_W-1:0] exc;
  logic             any_exc;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;

  rid_fields #(.WORD_W(WORD_W), .OP_W(OP_W), .REG_W(REG_W)) u_fields (
    .word_i(instr_i), .op_o(op), .opx_o(opx), .ra_o(ra), .rb_o(rb),
    .rc_o(rc), .imm5_o(imm5), .imm26_o(imm26), .imm16_o(imm16)
  );

  rid_primary_tbl #(.OP_W(OP_W), .SHADOW_EN(SHADOW_EN)) u_prim (
    .op_i(op), .dec_o(prim_dec)
  );

  rid_ext_tbl #(.OP_W(OP_W), .SHADOW_EN(SHADOW_EN)) u_ext (
    .opx_i(opx), .dec_o(ext_dec)
  );

  assign is_r = (op == R_OP);
  assign dec  = is_r ? ext_dec : prim_dec;

  rid_imm_unit #(.WORD_W(WORD_W), .OP_W(OP_W), .REG_W(REG_W)) u_imm (
    .fmt_i(dec.fmt), .mode_i(dec.imode), .imm16_i(imm16),
    .imm5_i(imm5), .imm26_i(imm26), .imm_o(imm_o)
  );

  // Priority: illegal, then unimplemented, then supervisor.
  always_comb begin
    exc = '0;
    if (dec.illegal)                   exc[EXC_ILL]    = 1'b1;
    else if (dec.unimpl)               exc[EXC_UNIMPL] = 1'b1;
    else if (dec.priv && user_mode_i)  exc[EXC_PRIV]   = 1'b1;
  end
  assign any_exc = |exc;

  always_comb begin
    case (dec.wsel)
      WB_B:    wb_reg_o = rb;
      WB_C:    wb_reg_o = rc;
      WB_LINK: wb_reg_o = LINK;
      default: wb_reg_o = '0;
    endcase
  end

  assign wb_en_o     = (dec.wsel != WB_NONE) && !any_exc && (wb_reg_o != '0);
  assign exc_o       = exc;
  assign exc_valid_o = any_exc;
  assign cls_o       = any_exc ? CL_EXC : dec.cls;
  assign fmt_o       = dec.fmt;
  assign opcode_o    = op;
  assign opx_o       = opx;
  assign ra_o        = ra;
  assign rb_o        = rb;
  assign rc_o        = rc;

  always_comb begin
    if (!$isunknown({instr_i, user_mode_i})) begin
      assert_exc_onehot_R12: assert ($onehot0(exc_o))
        else $error("more than one exception flag");
      assert_exc_blocks_wb_R12: assert (!(exc_valid_o && wb_en_o))
        else $error("write enabled with exception");
      assert_no_zero_wb_R11: assert (!wb_en_o || wb_reg_o != '0)
        else $error("write to register zero");
      assert_priv_needs_user_R9: assert (!exc_o[EXC_PRIV] || user_mode_i)
        else $error("supervisor fault outside user mode");
    end
  end
endmodule

// File: tb/tb_rid_decoder.sv
module tb_rid_decoder;
  import rid_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid, in_ready, out_valid, out_ready, um;
  logic [31:0] instr;
  logic [1:0]  fmt;
  logic [5:0]  opc, opx;
  logic [4:0]  ra, rb, rc, wbr;
  logic [31:0] imm;
  logic [3:0]  cls;
  logic        wbe, excv;
  logic [2:0]  exc;

  logic        s_ir, s_ov, s_wbe, s_excv;
  logic [1:0]  s_fmt;
  logic [5:0]  s_opc, s_opx;
  logic [4:0]  s_ra, s_rb, s_rc, s_wbr;
  logic [31:0] s_imm;
  logic [3:0]  s_cls;
  logic [2:0]  s_exc;

  rid_decoder dut (
    .in_valid(in_valid), .in_ready(in_ready), .instr_i(instr), .user_mode_i(um),
    .out_valid(out_valid), .out_ready(out_ready), .fmt_o(fmt), .opcode_o(opc),
    .opx_o(opx), .ra_o(ra), .rb_o(rb), .rc_o(rc), .imm_o(imm), .cls_o(cls),
    .wb_en_o(wbe), .wb_reg_o(wbr), .exc_o(exc), .exc_valid_o(excv)
  );

  rid_decoder #(.SHADOW_EN(1'b1)) dut_sh (
    .in_valid(in_valid), .in_ready(s_ir), .instr_i(instr), .user_mode_i(um),
    .out_valid(s_ov), .out_ready(out_ready), .fmt_o(s_fmt), .opcode_o(s_opc),
    .opx_o(s_opx), .ra_o(s_ra), .rb_o(s_rb), .rc_o(s_rc), .imm_o(s_imm),
    .cls_o(s_cls), .wb_en_o(s_wbe), .wb_reg_o(s_wbr), .exc_o(s_exc),
    .exc_valid_o(s_excv)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fi(int op, int a, int b, int im);
    return {a[4:0], b[4:0], im[15:0], op[5:0]};
  endfunction
  function automatic logic [31:0] fr(int ox, int a, int b, int c, int i5);
    return {a[4:0], b[4:0], c[4:0], ox[5:0], i5[4:0], 6'h3A};
  endfunction
  function automatic logic [31:0] fj(int op, int im);
    return {im[25:0], op[5:0]};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic        um;
    logic [3:0]  cls;
    logic [2:0]  exc;
    logic        wbe;
    logic [4:0]  wbr;
    logic [31:0] imm;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mv(logic [31:0] w, logic u, logic [3:0] c, logic [2:0] e,
                              logic we, logic [4:0] wr, logic [31:0] im, int rq);
    vec_t v;
    v = '{w: w, um: u, cls: c, exc: e, wbe: we, wbr: wr, imm: im, req: rq[7:0]};
    return v;
  endfunction

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    mv(fi('h04, 2, 3, 'hFFFC), 0, CL_ALU,    3'b000, 1, 3,  32'hFFFFFFFC, 3),  // R3 addi
    mv(fi('h0C, 1, 5, 'h8000), 0, CL_ALU,    3'b000, 1, 5,  32'h00008000, 4),  // R4 andi
    mv(fi('h34, 1, 6, 'h1234), 0, CL_ALU,    3'b000, 1, 6,  32'h12340000, 5),  // R5 orhi
    mv(fi('h30, 1, 8, 'hF000), 0, CL_CMP,    3'b000, 1, 8,  32'h0000F000, 4),  // R4 cmpltui
    mv(fi('h08, 1, 9, 'h8001), 0, CL_CMP,    3'b000, 1, 9,  32'hFFFF8001, 3),  // R3 cmpgei
    mv(fi('h17, 4, 7, 'hFFF0), 0, CL_LOAD,   3'b000, 1, 7,  32'hFFFFFFF0, 3),  // R3 ldw
    mv(fi('h15, 4, 7, 'h0010), 0, CL_STORE,  3'b000, 0, 0,  32'h00000010, 11), // R11 stw
    mv(fi('h26, 4, 7, 'hFFFC), 0, CL_BRANCH, 3'b000, 0, 0,  32'hFFFFFFFC, 3),  // R3 beq
    mv(fj('h00, 'h3FFFFFF),    0, CL_JUMP,   3'b000, 1, 31, 32'h03FFFFFF, 6),  // R6 call
    mv(fr('h31, 1, 2, 9, 0),   0, CL_ALU,    3'b000, 1, 9,  32'h00000000, 11), // R11 add
    mv(fr('h12, 1, 0, 4, 31),  0, CL_SHIFT,  3'b000, 1, 4,  32'h0000001F, 6),  // R6 slli
    mv(fr('h1D, 3, 0, 0, 0),   0, CL_JUMP,   3'b000, 1, 31, 32'h00000000, 11), // R11 callr
    mv(fr('h31, 1, 2, 0, 0),   0, CL_ALU,    3'b000, 0, 0,  32'h00000000, 11), // R11 r0 dest
    mv(fi('h04, 0, 0, 'h0000), 0, CL_ALU,    3'b000, 0, 0,  32'h00000000, 11), // R11 nop addi
    mv(fi('h02, 1, 2, 'h0001), 0, CL_EXC,    3'b001, 0, 0,  32'h00000001, 7),  // R7 primary
    mv(fr('h00, 1, 2, 3, 0),   0, CL_EXC,    3'b001, 0, 0,  32'h00000000, 7),  // R7 extended
    mv(fi('h32, 1, 2, 'h0002), 1, CL_EXC,    3'b010, 0, 0,  32'h00000002, 8),  // R8 custom
    mv(fr('h26, 0, 0, 5, 3),   1, CL_EXC,    3'b100, 0, 0,  32'h00000003, 9),  // R9 rdctl user
    mv(fr('h26, 0, 0, 5, 3),   0, CL_CTRL,   3'b000, 1, 5,  32'h00000003, 9),  // R9 rdctl sup
    mv(fr('h01, 29, 0, 0, 0),  1, CL_EXC,    3'b100, 0, 0,  32'h00000000, 9),  // R9 eret user
    mv(fr('h09, 25, 0, 0, 0),  0, CL_CTRL,   3'b000, 0, 0,  32'h00000000, 9),  // R9 bret sup
    mv(fr('h2E, 2, 0, 0, 1),   1, CL_EXC,    3'b100, 0, 0,  32'h00000001, 9),  // R9 wrctl user
    mv(fi('h1B, 2, 4, 'h0040), 0, CL_NOP,    3'b000, 0, 0,  32'h00000040, 13), // R13 flushda
    mv(fr('h0C, 2, 0, 4, 0),   0, CL_NOP,    3'b000, 0, 0,  32'h00000000, 13), // R13 flushi
    mv(fi('h38, 2, 4, 'h0008), 0, CL_EXC,    3'b001, 0, 0,  32'h00000008, 10), // R10 no shadow
    mv(fr('h25, 1, 2, 3, 0),   0, CL_DIV,    3'b000, 1, 3,  32'h00000000, 11), // R11 div
    mv(fr('h2D, 0, 0, 0, 5),   0, CL_TRAP,   3'b000, 0, 0,  32'h00000005, 11), // R11 trap
    mv(fi('h3C, 1, 0, 'hABCD), 0, CL_ALU,    3'b000, 0, 0,  32'hABCD0000, 5)   // R5 xorhi r0
  };

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R14 watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0; out_ready = 1'b0; um = 1'b0; instr = '0;
    @(negedge clk); #2;
    // R14: idle stream
    chk("R14 out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R14 in_ready idle", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1; in_valid = 1'b1; #1;
    chk("R14 in_ready follows", {31'd0, in_ready}, 32'd1);
    chk("R14 out_valid follows", {31'd0, out_valid}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = VECS[i].w;
      um    = VECS[i].um;
      #2;
      begin
        string t;
        logic [31:0] w;
        logic [1:0]  ef;
        w = VECS[i].w;
        t = $sformatf("R%0d vec%0d", VECS[i].req, i);
        chk({t, " cls"}, {28'd0, cls}, {28'd0, VECS[i].cls});
        chk({t, " exc"}, {29'd0, exc}, {29'd0, VECS[i].exc});
        chk({t, " R12 excv"}, {31'd0, excv}, {31'd0, |VECS[i].exc});
        chk({t, " wbe"}, {31'd0, wbe}, {31'd0, VECS[i].wbe});
        if (VECS[i].wbe) chk({t, " wbr"}, {27'd0, wbr}, {27'd0, VECS[i].wbr});
        chk({t, " imm"}, imm, VECS[i].imm);
        ef = (w[5:0] == 6'h3A) ? 2'd1 : (w[5:0] < 6'h02) ? 2'd2 : 2'd0;
        chk({t, " R2 fmt"}, {30'd0, fmt}, {30'd0, ef});
        chk({t, " R1 fields"}, {opc, opx, ra, rb, rc, 5'd0},
            {w[5:0], w[16:11], w[31:27], w[26:22], w[21:17], 5'd0});
      end
    end

    // R10: shadow-register opcodes on the SHADOW_EN=1 copy
    @(negedge clk); instr = fi('h38, 2, 4, 'hFFF8); um = 1'b0; #2;
    chk("R10 rdprs cls", {28'd0, s_cls}, {28'd0, CL_CTRL});
    chk("R10 rdprs wb", {26'd0, s_wbe, s_wbr}, {26'd0, 1'b1, 5'd4});
    chk("R10 rdprs imm", s_imm, 32'hFFFFFFF8);
    chk("R10 rdprs off", {29'd0, exc}, 32'd1);
    um = 1'b1; #2;
    chk("R10 rdprs user", {29'd0, s_exc}, 32'd4);
    @(negedge clk); instr = fr('h14, 3, 0, 0, 0); um = 1'b0; #2;
    chk("R10 wrprs cls", {28'd0, s_cls}, {28'd0, CL_CTRL});
    chk("R10 wrprs nowb", {31'd0, s_wbe}, 32'd0);
    chk("R10 wrprs off", {29'd0, exc}, 32'd1);
    um = 1'b1; #2;
    chk("R10 wrprs user", {29'd0, s_exc}, 32'd4);

    // R7 beats R9: illegal extended opcode in user mode stays illegal only
    @(negedge clk); instr = fr('h3F, 1, 1, 1, 0); um = 1'b1; #2;
    chk("R7 prio", {29'd0, exc}, 32'd1);
    // R13: no-op extended opcode
    @(negedge clk); instr = fr('h36, 1, 2, 3, 0); um = 1'b1; #2;
    chk("R13 nop", {26'd0, cls, excv, wbe}, {26'd0, CL_NOP, 1'b0, 1'b0});
    // R4: zero-extended xori
    @(negedge clk); instr = fi('h1C, 1, 2, 'hFFFF); um = 1'b0; #2;
    chk("R4 xori", imm, 32'h0000FFFF);
    // R14: back-pressure passes through combinationally
    out_ready = 1'b0; #1;
    chk("R14 stall", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b0; #1;
    chk("R14 drop valid", {31'd0, out_valid}, 32'd0);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule